// File: doc/BRIEF.md
# Row Hit Sparsifier With Two-Level Run Limits

This block compresses one sensor row at a time. Each row arrives as a vector of binary discriminator decisions, one bit per column. Zero pixels are removed. Fired pixels are described as short horizontal runs, each with a start column and a length of one to four.

The work happens in two steps. First, every fixed-width column group scans its own slice in parallel, from the lowest column upward. A group records only a limited number of runs. Second, a collector walks the recorded runs of all groups, lowest group first, and keeps only a limited number for the whole row. The kept runs, preceded by a row header, are written as 16-bit words into one of several output memories. Whenever a limit drops runs, the header of that row flags it.

The memories are filled in rotation, one frame of rows per memory. Each completed frame is announced with a pulse, the memory index and a word count. A reader drains the memory through a read port and then hands it back with a release strobe.

Top module: `hit_sparsifier`

## Requirements
- R1: A row is taken in a cycle where `ready` and `in_valid` are both high. After that cycle, `ready` stays low for exactly GRP_COLS + 2 + NUM_GRPS*GRP_MAX_RUNS cycles, whatever the row holds. This is 14 cycles in the bench configuration.
- R2: Runs never cross a group boundary. Two fired pixels on either side of a boundary give two separate runs.
- R3: A run is at most RUN_MAX_LEN (4) pixels long. A longer stretch of fired pixels is cut into consecutive runs of 4, followed by one run for the remainder.
- R4: A group keeps at most GRP_MAX_RUNS runs, which are its lowest-column runs. Any further runs in that group are dropped, and header bit 3 is set for the row.
- R5: A row keeps at most ROW_MAX_RUNS runs, taken from the lowest-numbered groups first. Any further runs are dropped, and header bit 2 is set.
- R6: Every row writes a header first, even a row with no hits. Bit 15 = 1, bits 14:4 = row number, bit 3 = group overflow, bit 2 = row overflow, bits 1:0 = 0. The header is followed by the kept runs in ascending column order.
- R7: A run word has bit 15 = 0, bits 14:4 = absolute start column, bits 3:2 = length minus one, and bits 1:0 = 0.
- R8: Rows are stored in frames of FRAME_ROWS rows per memory, and the memories are used in the order 0, 1, …, NUM_MEMS-1, then 0 again. When a frame's last row finishes:
  - `frame_done` pulses for one cycle, in the same cycle that `ready` returns;
  - `frame_mem` gives the memory that was just filled;
  - `frame_words` gives the number of words written to it.
  That memory is then marked full.
- R9: A row that starts while the current memory is full sets `wr_err`, which stays set until reset. Nothing is written for that row, and it does not count toward a frame.
- R10: `rd_data` shows the word at `rd_addr` in memory `rd_sel` one cycle after the address is presented. A `mem_release` pulse clears the full mark of `mem_release_sel`.
- R11: After reset, `ready` = 1, `frame_done` = 0, `wr_err` = 0, and filling starts with memory 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Row present |
| in_row | input | NUM_COLS | Discriminator bits, bit i = column i |
| in_row_id | input | 11 | Row number for the header |
| ready | output | 1 | Block can take a row |
| rd_sel | input | clog2(NUM_MEMS) | Memory to read |
| rd_addr | input | clog2(MEM_DEPTH) | Word address to read |
| rd_data | output | 16 | Read word, one cycle latency |
| mem_release | input | 1 | Return a memory to the writer |
| mem_release_sel | input | clog2(NUM_MEMS) | Memory being returned |
| frame_done | output | 1 | One-cycle frame completion pulse |
| frame_mem | output | clog2(NUM_MEMS) | Memory of the completed frame |
| frame_words | output | clog2(MEM_DEPTH+1) | Words in the completed frame |
| wr_err | output | 1 | Sticky write-to-full error |

## Verification
The bench builds the block with 16 columns split into two groups of 8. It sets 2 runs per group, 3 per row, 4 memories of 16 words and 2 rows per frame. With these sizes the group limit, the row limit and the length split can all be hit by short patterns. Every one of the 256 values of a group slice is swept in both groups, paired with derived patterns in the other group. The test also cycles through all four memories many times, fills every memory to force the full-memory error, and then recovers from it.

// File: rtl/hs_pkg.sv
package hs_pkg;
  localparam int WORD_W = 16;
  localparam int FLD_W  = 11;

  typedef enum logic [1:0] {ST_IDLE, ST_SCAN, ST_COLLECT, ST_HEAD} hs_state_e;

  function automatic logic [WORD_W-1:0] run_word(input logic [FLD_W-1:0] col,
                                                 input logic [1:0] len_m1);
    return {1'b0, col, len_m1, 2'b00};
  endfunction

  function automatic logic [WORD_W-1:0] head_word(input logic [FLD_W-1:0] row,
                                                  input logic gov, input logic rov);
    return {1'b1, row, gov, rov, 2'b00};
  endfunction
endpackage

// File: rtl/hs_group_scan.sv
module hs_group_scan #(
  parameter int GRP_COLS = 64,
  parameter int MAX_RUNS = 6,
  parameter int RUN_MAX  = 4,
  parameter int BASE     = 0,
  localparam int CW = $clog2(GRP_COLS + 1),
  localparam int NW = $clog2(MAX_RUNS + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic                    step,
  input  logic [CW-1:0]           col,
  input  logic [GRP_COLS-1:0]     bits,
  output logic [MAX_RUNS*11-1:0]  run_col,
  output logic [MAX_RUNS*2-1:0]   run_lm1,
  output logic [NW-1:0]           run_cnt,
  output logic                    ovf
);
  localparam int LW = $clog2(RUN_MAX + 1);

  logic [GRP_COLS:0] ext;
  logic              hit, emit, open_q;
  logic [CW-1:0]     st_q;
  logic [LW-1:0]     len_q;
  logic [10:0]       col_a [MAX_RUNS];
  logic [1:0]        lm1_a [MAX_RUNS];

  assign ext  = {1'b0, bits};
  assign hit  = ext[col];
  assign emit = open_q && (!hit || len_q == LW'(RUN_MAX));

  always_ff @(posedge clk) begin
    if (rst || start) begin
      open_q  <= 1'b0;
      st_q    <= '0;
      len_q   <= '0;
      run_cnt <= '0;
      ovf     <= 1'b0;
    end else if (step) begin
      if (emit) begin
        if (run_cnt < NW'(MAX_RUNS)) begin
          for (int i = 0; i < MAX_RUNS; i++) begin
            if (run_cnt == NW'(i)) begin
              col_a[i] <= 11'(BASE) + 11'(st_q);
              lm1_a[i] <= 2'(len_q - LW'(1));
            end
          end
          run_cnt <= run_cnt + NW'(1);
        end else begin
          ovf <= 1'b1;
        end
      end
      if (hit && (!open_q || len_q == LW'(RUN_MAX))) begin
        open_q <= 1'b1;
        st_q   <= col;
        len_q  <= LW'(1);
      end else if (hit) begin
        len_q <= len_q + LW'(1);
      end else begin
        open_q <= 1'b0;
      end
    end
  end

  for (genvar i = 0; i < MAX_RUNS; i++) begin : g_flat
    assign run_col[i*11 +: 11] = col_a[i];
    assign run_lm1[i*2 +: 2]   = lm1_a[i];
  end
endmodule

// File: rtl/hs_ram.sv
module hs_ram #(
  parameter int DEPTH = 512,
  parameter int W     = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/hit_sparsifier.sv
module hit_sparsifier #(
  parameter int NUM_COLS     = 256,
  parameter int GRP_COLS     = 64,
  parameter int GRP_MAX_RUNS = 6,
  parameter int ROW_MAX_RUNS = 9,
  parameter int RUN_MAX_LEN  = 4,
  parameter int NUM_MEMS     = 4,
  parameter int MEM_DEPTH    = 512,
  parameter int FRAME_ROWS   = 32,
  localparam int SW  = $clog2(NUM_MEMS),
  localparam int AW  = $clog2(MEM_DEPTH),
  localparam int FWW = $clog2(MEM_DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [NUM_COLS-1:0] in_row,
  input  logic [10:0]         in_row_id,
  output logic                ready,
  input  logic [SW-1:0]       rd_sel,
  input  logic [AW-1:0]       rd_addr,
  output logic [15:0]         rd_data,
  input  logic                mem_release,
  input  logic [SW-1:0]       mem_release_sel,
  output logic                frame_done,
  output logic [SW-1:0]       frame_mem,
  output logic [FWW-1:0]      frame_words,
  output logic                wr_err
);
  import hs_pkg::*;

  localparam int NUM_GRPS = NUM_COLS / GRP_COLS;
  localparam int CW  = $clog2(GRP_COLS + 1);
  localparam int NW  = $clog2(GRP_MAX_RUNS + 1);
  localparam int GW  = (NUM_GRPS > 1) ? $clog2(NUM_GRPS) : 1;
  localparam int KW  = (GRP_MAX_RUNS > 1) ? $clog2(GRP_MAX_RUNS) : 1;
  localparam int RCW = $clog2(ROW_MAX_RUNS + 1);
  localparam int FRW = $clog2(FRAME_ROWS + 1);

  hs_state_e            state_q;
  logic [NUM_COLS-1:0]  row_q;
  logic [10:0]          rid_q;
  logic [CW-1:0]        col_q;
  logic [GW-1:0]        g_q;
  logic [KW-1:0]        k_q;
  logic [RCW-1:0]       rcnt_q;
  logic                 rovf_q, discard_q;
  logic [AW-1:0]        base_q, wptr_q;
  logic [FRW-1:0]       frows_q;
  logic [SW-1:0]        cur_q, rd_sel_q;
  logic [NUM_MEMS-1:0]  full_q;
  logic                 accept;

  logic [GRP_MAX_RUNS*11-1:0] g_col [NUM_GRPS];
  logic [GRP_MAX_RUNS*2-1:0]  g_lm1 [NUM_GRPS];
  logic [NW-1:0]              g_cnt [NUM_GRPS];
  logic [NUM_GRPS-1:0]        g_ovf;

  assign ready  = (state_q == ST_IDLE);
  assign accept = ready && in_valid;

  for (genvar g = 0; g < NUM_GRPS; g++) begin : g_grp
    hs_group_scan #(
      .GRP_COLS(GRP_COLS), .MAX_RUNS(GRP_MAX_RUNS),
      .RUN_MAX(RUN_MAX_LEN), .BASE(g * GRP_COLS)
    ) scan_i (
      .clk(clk), .rst(rst), .start(accept), .step(state_q == ST_SCAN),
      .col(col_q), .bits(row_q[g*GRP_COLS +: GRP_COLS]),
      .run_col(g_col[g]), .run_lm1(g_lm1[g]), .run_cnt(g_cnt[g]), .ovf(g_ovf[g])
    );
  end

  logic        sel_valid, row_room;
  logic [10:0] sel_col;
  logic [1:0]  sel_lm1;
  assign sel_valid = int'(k_q) < int'(g_cnt[g_q]);
  assign sel_col   = g_col[g_q][int'(k_q)*11 +: 11];
  assign sel_lm1   = g_lm1[g_q][int'(k_q)*2 +: 2];
  assign row_room  = rcnt_q < RCW'(ROW_MAX_RUNS);

  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [15:0]   wr_data;
  always_comb begin
    wr_en   = 1'b0;
    wr_addr = base_q;
    wr_data = head_word(rid_q, |g_ovf, rovf_q);
    if (state_q == ST_COLLECT) begin
      wr_en   = sel_valid && row_room && !discard_q;
      wr_addr = base_q + AW'(1) + AW'(rcnt_q);
      wr_data = run_word(sel_col, sel_lm1);
    end else if (state_q == ST_HEAD) begin
      wr_en = !discard_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      col_q       <= '0;
      g_q         <= '0;
      k_q         <= '0;
      rcnt_q      <= '0;
      rovf_q      <= 1'b0;
      discard_q   <= 1'b0;
      base_q      <= '0;
      wptr_q      <= '0;
      frows_q     <= '0;
      cur_q       <= '0;
      full_q      <= '0;
      wr_err      <= 1'b0;
      frame_done  <= 1'b0;
      frame_mem   <= '0;
      frame_words <= '0;
      rd_sel_q    <= '0;
    end else begin
      rd_sel_q   <= rd_sel;
      frame_done <= 1'b0;
      if (mem_release) full_q[mem_release_sel] <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (in_valid) begin
          row_q     <= in_row;
          rid_q     <= in_row_id;
          col_q     <= '0;
          base_q    <= wptr_q;
          rcnt_q    <= '0;
          rovf_q    <= 1'b0;
          discard_q <= full_q[cur_q];
          if (full_q[cur_q]) wr_err <= 1'b1;
          state_q   <= ST_SCAN;
        end
        ST_SCAN: begin
          col_q <= col_q + CW'(1);
          if (col_q == CW'(GRP_COLS)) begin
            g_q     <= '0;
            k_q     <= '0;
            state_q <= ST_COLLECT;
          end
        end
        ST_COLLECT: begin
          if (sel_valid) begin
            if (row_room) rcnt_q <= rcnt_q + RCW'(1);
            else          rovf_q <= 1'b1;
          end
          if (k_q == KW'(GRP_MAX_RUNS - 1)) begin
            k_q <= '0;
            if (g_q == GW'(NUM_GRPS - 1)) state_q <= ST_HEAD;
            else                          g_q <= g_q + GW'(1);
          end else begin
            k_q <= k_q + KW'(1);
          end
        end
        ST_HEAD: begin
          state_q <= ST_IDLE;
          if (!discard_q) begin
            if (frows_q == FRW'(FRAME_ROWS - 1)) begin
              frame_done    <= 1'b1;
              frame_mem     <= cur_q;
              frame_words   <= FWW'(base_q) + FWW'(rcnt_q) + FWW'(1);
              full_q[cur_q] <= 1'b1;
              cur_q         <= (cur_q == SW'(NUM_MEMS - 1)) ? '0 : cur_q + SW'(1);
              wptr_q        <= '0;
              frows_q       <= '0;
            end else begin
              wptr_q  <= base_q + AW'(rcnt_q) + AW'(1);
              frows_q <= frows_q + FRW'(1);
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  logic [15:0] rq [NUM_MEMS];
  for (genvar m = 0; m < NUM_MEMS; m++) begin : g_mem
    hs_ram #(.DEPTH(MEM_DEPTH), .W(16)) ram_i (
      .clk(clk), .we(wr_en && cur_q == SW'(m)), .waddr(wr_addr), .wdata(wr_data),
      .raddr(rd_addr), .rdata(rq[m])
    );
  end
  assign rd_data = rq[rd_sel_q];
endmodule

// File: rtl/hs_chk.sv
module hs_chk #(
  parameter int BUSY         = 14,
  parameter int NUM_MEMS     = 4,
  parameter int FRAME_ROWS   = 2,
  parameter int ROW_MAX_RUNS = 3,
  parameter int SW           = 2,
  parameter int FWW          = 5
) (
  input logic           clk,
  input logic           rst,
  input logic           in_valid,
  input logic           ready,
  input logic           frame_done,
  input logic [SW-1:0]  frame_mem,
  input logic [FWW-1:0] frame_words,
  input logic           wr_err
);
  logic [15:0]   busy_cnt;
  logic [SW-1:0] next_mem;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_cnt <= '0;
      next_mem <= '0;
    end else begin
      busy_cnt <= ready ? '0 : busy_cnt + 16'd1;
      if (frame_done) next_mem <= (next_mem == SW'(NUM_MEMS - 1)) ? '0 : next_mem + SW'(1);
    end
  end

  AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> busy_cnt == 16'(BUSY)); // R1
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
    ready && in_valid |=> !ready); // R1
  AST_FRAME_PULSE: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> !frame_done); // R8
  AST_FRAME_ORDER: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> frame_mem == next_mem); // R8
  AST_FRAME_WORDS: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> (int'(frame_words) >= FRAME_ROWS &&
                    int'(frame_words) <= FRAME_ROWS * (1 + ROW_MAX_RUNS))); // R5
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    wr_err |=> wr_err); // R9
endmodule

bind hit_sparsifier hs_chk #(
  .BUSY(GRP_COLS + 2 + (NUM_COLS / GRP_COLS) * GRP_MAX_RUNS),
  .NUM_MEMS(NUM_MEMS), .FRAME_ROWS(FRAME_ROWS), .ROW_MAX_RUNS(ROW_MAX_RUNS),
  .SW(SW), .FWW(FWW)
) chk_i (
  .clk(clk), .rst(rst), .in_valid(in_valid), .ready(ready),
  .frame_done(frame_done), .frame_mem(frame_mem), .frame_words(frame_words),
  .wr_err(wr_err)
);

// File: tb/hit_sparsifier_tb_top.sv
`timescale 1ns/1ps
module hit_sparsifier_tb_top;
  localparam int COLS = 16, GRP = 8, MAXG = 2, MAXR = 3, RUNL = 4;
  localparam int NM = 4, DEPTH = 16, FR = 2;
  localparam int BUSY = GRP + 2 + (COLS / GRP) * MAXG;

  logic clk = 0, rst = 1;
  logic in_valid = 0;
  logic [COLS-1:0] in_row = '0;
  logic [10:0] in_row_id = '0;
  logic ready, frame_done, wr_err, mem_release = 0;
  logic [1:0] rd_sel = '0, mem_release_sel = '0, frame_mem;
  logic [3:0] rd_addr = '0;
  logic [15:0] rd_data;
  logic [4:0] frame_words;

  always #2 clk = ~clk;

  hit_sparsifier #(
    .NUM_COLS(COLS), .GRP_COLS(GRP), .GRP_MAX_RUNS(MAXG), .ROW_MAX_RUNS(MAXR),
    .RUN_MAX_LEN(RUNL), .NUM_MEMS(NM), .MEM_DEPTH(DEPTH), .FRAME_ROWS(FR)
  ) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_row(in_row), .in_row_id(in_row_id),
    .ready(ready), .rd_sel(rd_sel), .rd_addr(rd_addr), .rd_data(rd_data),
    .mem_release(mem_release), .mem_release_sel(mem_release_sel),
    .frame_done(frame_done), .frame_mem(frame_mem), .frame_words(frame_words),
    .wr_err(wr_err)
  );

  int checks = 0, fails = 0;
  int rid = 0, exp_mem = 0, exp_n = 0;
  logic [15:0] exp_words [64];
  logic [15:0] hdr_by_mem [NM];
  logic fd;
  logic [1:0] fm;
  logic [4:0] fw;
  int lowcnt;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Expected words of one row: header, then kept runs in column order.
  task automatic add_row(input logic [COLS-1:0] bits, input int id);
    int hi = exp_n;
    int kept = 0;
    logic gov = 0, rov = 0;
    exp_n++;
    for (int g = 0; g < COLS / GRP; g++) begin
      int found = 0;
      int c = 0;
      while (c < GRP) begin
        if (bits[g*GRP + c]) begin
          int s = c;
          int l = 0;
          while (c < GRP && bits[g*GRP + c] && l < RUNL) begin l++; c++; end
          if (found < MAXG) begin
            found++;
            if (kept < MAXR) begin
              exp_words[exp_n] = {1'b0, 11'(g*GRP + s), 2'(l - 1), 2'b00};
              exp_n++;
              kept++;
            end else rov = 1;
          end else gov = 1;
        end else c++;
      end
    end
    exp_words[hi] = {1'b1, 11'(id), gov, rov, 2'b00};
  endtask

  task automatic send_row(input logic [COLS-1:0] bits);
    in_valid = 1; in_row = bits; in_row_id = 11'(rid);
    @(negedge clk);
    in_valid = 0;
    lowcnt = 0;
    while (!ready) begin lowcnt++; @(negedge clk); end
    fd = frame_done; fm = frame_mem; fw = frame_words;
    rid++;
    chk(lowcnt == BUSY, "R1 busy cycles", lowcnt, BUSY);
  endtask

  task automatic rd_word(input int sel, input int addr, output logic [15:0] d);
    rd_sel = 2'(sel); rd_addr = 4'(addr);
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic release_mem(input int m);
    mem_release = 1; mem_release_sel = 2'(m);
    @(negedge clk);
    mem_release = 0;
  endtask

  task automatic run_frame(input logic [COLS-1:0] a, input logic [COLS-1:0] b,
                           input string tag, input bit rel);
    logic [15:0] d;
    exp_n = 0;
    add_row(a, rid);
    add_row(b, rid + 1);
    send_row(a);
    chk(!fd, "R8 no pulse mid-frame", fd, 0);
    send_row(b);
    chk(fd, "R8 frame_done", fd, 1);
    chk(int'(fm) == exp_mem, "R8 frame_mem rotation", fm, exp_mem);
    chk(int'(fw) == exp_n, "R8 frame_words", fw, exp_n);
    for (int i = 0; i < exp_n; i++) begin
      rd_word(exp_mem, i, d);
      chk(d == exp_words[i], tag, d, exp_words[i]);
    end
    hdr_by_mem[exp_mem] = exp_words[0];
    if (rel) release_mem(exp_mem);
    exp_mem = (exp_mem + 1) % NM;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(ready == 1, "R11 ready after reset", ready, 1);
    chk(frame_done == 0, "R11 frame_done after reset", frame_done, 0);
    chk(wr_err == 0, "R11 wr_err after reset", wr_err, 0);

    run_frame(16'h0000, 16'h0000, "R6 empty rows header only", 1);
    run_frame(16'h003E, 16'h00FF, "R3 run split at four", 1);
    run_frame(16'h00AA, 16'h5500, "R4 group limit", 1);
    run_frame(16'h5050, 16'hAAAA, "R5 row limit lowest groups", 1);
    run_frame(16'h0180, 16'hFFFF, "R2 group boundary", 1);
    run_frame(16'h1248, 16'h8001, "R7 run word layout", 1);

    for (int p = 0; p < 256; p++) begin
      run_frame({8'(p * 37 + 11), 8'(p)}, {8'(p), 8'(p ^ 8'h3C)}, "R2 sweep words", 1);
    end

    // R9: fill every memory, then push a row into a full one.
    for (int f = 0; f < NM; f++) run_frame(16'(f * 16'h0101 + 16'h0003), 16'h0810, "R10 read back", 0);
    chk(wr_err == 0, "R9 no error before overflow", wr_err, 0);
    send_row(16'hFFFF);
    chk(wr_err == 1, "R9 error on full memory", wr_err, 1);
    chk(!fd, "R9 discarded row no frame", fd, 0);
    rd_word(exp_mem, 0, d);
    chk(d == hdr_by_mem[exp_mem], "R9 full memory untouched", d, hdr_by_mem[exp_mem]);
    for (int m = 0; m < NM; m++) release_mem(m);
    run_frame(16'h0C03, 16'h0000, "R9 frame after discard", 1);
    chk(wr_err == 1, "R9 error sticky", wr_err, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule